// File: doc/BRIEF.md
# Pseudorandom Byte Generator with CRC16 Accumulator

This block keeps one 16-bit linear-feedback shift register and uses it in three ways. It can hand out pseudorandom bytes, be seeded one byte at a time, or accumulate a CRC16 over a stream of bytes. The register uses the polynomial x^16 + x^15 + x^2 + 1. It is fully visible at all times as a high readback byte and a low readback byte. Each advance of the register is built from one feedback step, defined as follows:

1. The feedback bit is the register's top bit XOR the input bit.
2. The register shifts left by one.
3. The feedback bit enters bit 0 and is also XORed into bits 2 and 15.

A random advance chains thirteen such steps with a zero input bit, all inside a single clock cycle. A CRC advance chains eight steps, one per data bit, starting from the byte's most significant bit. The CRC path can therefore take a new byte every cycle.

CRC bytes arrive on a valid/ready stream. A byte is absorbed on a clock edge where `crc_valid` and `crc_ready` are both high. `crc_ready` drops only in a cycle that carries a seed write, because the seed write wins that cycle. The sender must then hold the byte and its valid until a later cycle. Seed writes, control writes and the random-consume strobe are plain single-cycle pulses.

A 2-bit control field selects the generator's behaviour:

| Code | Behaviour |
|------|-----------|
| 00 | Free run: each consume strobe triggers one random advance. |
| 10 | Same as 00. |
| 01 | One-shot: performs a single random advance, then returns to 00 by itself. |
| 11 | Off: consume strobes are ignored. |

Top module: `lfsr_rng_crc`

## Requirements
- R1: After reset the register reads 0x0000 (`state_hi` = 0x00, `state_lo` = 0x00) and the control field reads 00.
- R2: With the control field at 00 or 10, a consume strobe replaces the register, at the next clock edge, with the result of thirteen feedback steps with input bit 0. A cycle with no strobe, no write and no pending one-shot leaves the register unchanged.
- R3: Writing code 01 to the control field makes the register perform exactly one thirteen-step random advance at the following edge, and at that same edge the field returns to 00 by itself. Any other written code simply replaces the field.
- R4: With the control field at 11, consume strobes have no effect on the register.
- R5: A seed write moves the register's low byte into its high byte and loads the written byte into the low byte. Two seed writes in a row therefore set all 16 bits.
- R6: An accepted CRC byte advances the register by eight feedback steps, whose input bits are the byte's bits from bit 7 down to bit 0. Bytes are accepted on consecutive cycles with no gap. From 0x0000, the ASCII bytes "123456789" leave 0x FEE8.
- R7: Within one cycle a seed write outranks an accepted CRC byte, which outranks a random advance. `crc_ready` is low exactly in cycles with a seed write. A one-shot blocked by a seed write or an accepted CRC byte stays pending at 01.
- R8: The values 0x0000 and 0x8003 are unchanged by a random advance.
- R9: `state_hi`/`state_lo` always show the current register value. The register and the control field change only on clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_wr | input | 1 | Seed write strobe |
| seed_byte | input | 8 | Byte shifted into the low end on a seed write |
| crc_valid | input | 1 | CRC byte present |
| crc_byte | input | 8 | Byte to fold into the CRC |
| crc_ready | output | 1 | CRC byte can be absorbed this cycle |
| ctl_wr | input | 1 | Control field write strobe |
| ctl_wdata | input | 2 | New control code |
| ctl_rdata | output | 2 | Current control code |
| consume | input | 1 | Request for a fresh random value |
| state_hi | output | 8 | Register bits 15..8 |
| state_lo | output | 8 | Register bits 7..0, the current random byte |

## Verification
The bench builds the block with its defaults: a 16-bit register, 8-bit bytes, thirteen steps per random advance and the 0x8005 feedback mask. These are the values for which the standard CRC16 check string yields a known result. They also make the two lock-up seeds 0x0000 and 0x8003 reachable by two seed writes. With these defaults, seed-then-consume sequences, streams of back-to-back CRC bytes and same-cycle collisions of all three register-changing sources can each be compared against an arithmetic reference on every edge.

// File: rtl/lfsr_rng_pkg.sv
package lfsr_rng_pkg;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned OCTET_W = 8;

  // Control codes of the generator.
  typedef enum logic [1:0] {
    CTL_RUN     = 2'b00,
    CTL_ONCE    = 2'b01,
    CTL_RUN_ALT = 2'b10,
    CTL_OFF     = 2'b11
  } ctl_e;

  // Source that updates the register in a cycle, highest priority first.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SEED = 2'd1,
    SRC_CRC  = 2'd2,
    SRC_RAND = 2'd3
  } src_e;

endpackage

// File: rtl/lfsr_step.sv
// One feedback step: fb = top ^ din, shift left, fold fb through the mask.
module lfsr_step #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    POLY = 16'h8005
) (
  input  logic [W-1:0] s_i,
  input  logic         din,
  output logic [W-1:0] s_o
);

  logic fb;

  always_comb begin
    fb  = s_i[W-1] ^ din;
    s_o = {s_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

endmodule

// File: rtl/lfsr_unroll.sv
// STEPS chained feedback steps; step k uses din[STEPS-1-k] (MSB first).
module lfsr_unroll #(
  parameter int unsigned  W     = 16,
  parameter logic [W-1:0] POLY  = 16'h8005,
  parameter int unsigned  STEPS = 8
) (
  input  logic [W-1:0]     s_i,
  input  logic [STEPS-1:0] din,
  output logic [W-1:0]     s_o
);

  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = s_i;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    lfsr_step #(.W(W), .POLY(POLY)) u_step (
      .s_i (chain[k]),
      .din (din[STEPS-1-k]),
      .s_o (chain[k+1])
    );
  end

  assign s_o = chain[STEPS];

endmodule

// File: rtl/lfsr_ctrl.sv
// Control field, one-shot self-clear and update-source arbitration.
module lfsr_ctrl
  import lfsr_rng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed_wr,
  input  logic       crc_valid,
  input  logic       consume,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic       crc_ready,
  output src_e       src,
  output logic [1:0] ctl_q
);

  ctl_e ctl_r;
  ctl_e ctl_nx;
  logic crc_take;
  logic rand_want;

  always_comb begin
    crc_ready = ~seed_wr;
    crc_take  = crc_valid & crc_ready;
    rand_want = (ctl_r == CTL_ONCE) |
                (consume & (ctl_r != CTL_OFF));
    if (seed_wr)        src = SRC_SEED;
    else if (crc_take)  src = SRC_CRC;
    else if (rand_want) src = SRC_RAND;
    else                src = SRC_NONE;
  end

  always_comb begin
    ctl_nx = ctl_r;
    if (ctl_wr)
      ctl_nx = ctl_e'(ctl_wdata);
    else if (ctl_r == CTL_ONCE && src == SRC_RAND)
      ctl_nx = CTL_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_r <= CTL_RUN;
    else        ctl_r <= ctl_nx;
  end

  assign ctl_q = ctl_r;

endmodule

// File: rtl/lfsr_rng_crc.sv
module lfsr_rng_crc
  import lfsr_rng_pkg::*;
#(
  parameter int unsigned          LFSR_W    = REG_W,
  parameter int unsigned          BYTE_W    = OCTET_W,
  parameter int unsigned          RND_STEPS = 13,
  parameter logic [LFSR_W-1:0]    POLY      = 16'h8005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_wr,
  input  logic [BYTE_W-1:0] seed_byte,
  input  logic              crc_valid,
  input  logic [BYTE_W-1:0] crc_byte,
  output logic              crc_ready,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_rdata,
  input  logic              consume,
  output logic [BYTE_W-1:0] state_hi,
  output logic [BYTE_W-1:0] state_lo
);

  localparam int unsigned KEEP_W = LFSR_W - BYTE_W;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;
  logic [LFSR_W-1:0] rand_nx;
  logic [LFSR_W-1:0] crc_nx;
  logic [LFSR_W-1:0] seed_nx;
  src_e              src;

  lfsr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_wr   (seed_wr),
    .crc_valid (crc_valid),
    .consume   (consume),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .crc_ready (crc_ready),
    .src       (src),
    .ctl_q     (ctl_rdata)
  );

  // Random advance: input bits all zero.
  lfsr_unroll #(.W(LFSR_W), .POLY(POLY), .STEPS(RND_STEPS)) u_rand (
    .s_i (lfsr_q),
    .din ({RND_STEPS{1'b0}}),
    .s_o (rand_nx)
  );

  // CRC advance: one step per data bit, MSB first.
  lfsr_unroll #(.W(LFSR_W), .POLY(POLY), .STEPS(BYTE_W)) u_crc (
    .s_i (lfsr_q),
    .din (crc_byte),
    .s_o (crc_nx)
  );

  assign seed_nx = {lfsr_q[KEEP_W-1:0], seed_byte};

  always_comb begin
    unique case (src)
      SRC_SEED: lfsr_d = seed_nx;
      SRC_CRC:  lfsr_d = crc_nx;
      SRC_RAND: lfsr_d = rand_nx;
      default:  lfsr_d = lfsr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= '0;
    else        lfsr_q <= lfsr_d;
  end

  assign state_hi = lfsr_q[LFSR_W-1 -: BYTE_W];
  assign state_lo = lfsr_q[BYTE_W-1:0];

endmodule

// File: rtl/lfsr_rng_crc_chk.sv
module lfsr_rng_crc_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_wr,
  input logic [BYTE_W-1:0] seed_byte,
  input logic              crc_valid,
  input logic              crc_ready,
  input logic              ctl_wr,
  input logic [1:0]        ctl_wdata,
  input logic [1:0]        ctl_rdata,
  input logic              consume,
  input logic [BYTE_W-1:0] state_hi,
  input logic [BYTE_W-1:0] state_lo
);

  logic quiet;
  assign quiet = !seed_wr && !crc_valid && !ctl_wr;

  AST_SEED_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    seed_wr |=> (state_lo == $past(seed_byte)) && (state_hi == $past(state_lo))); // R5

  AST_SEED_BEATS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_wr && crc_valid) |=> state_lo == $past(seed_byte)); // R7

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == $past(ctl_wdata)); // R3

  AST_ONCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata == 2'b01 && quiet) |=> ctl_rdata == 2'b00); // R3

  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata == 2'b11 && quiet) |=> $stable({state_hi, state_lo})); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !consume && ctl_rdata != 2'b01) |=> $stable({state_hi, state_lo})); // R2

  AST_FIXED_8003: assert property (@(posedge clk) disable iff (!rst_n)
    ({state_hi, state_lo} == 16'h8003 && quiet) |=> {state_hi, state_lo} == 16'h8003); // R8

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ({state_hi, state_lo} == 16'h0000 && quiet) |=> {state_hi, state_lo} == 16'h0000); // R8

  AST_READY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_valid && crc_ready) |-> !seed_wr); // R7

endmodule

bind lfsr_rng_crc lfsr_rng_crc_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seed_wr   (seed_wr),
  .seed_byte (seed_byte),
  .crc_valid (crc_valid),
  .crc_ready (crc_ready),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .consume   (consume),
  .state_hi  (state_hi),
  .state_lo  (state_lo)
);

// File: tb/lfsr_rng_crc_bench.sv
module lfsr_rng_crc_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       seed_wr;
  logic [7:0] seed_byte;
  logic       crc_valid;
  logic [7:0] crc_byte;
  logic       crc_ready;
  logic       ctl_wr;
  logic [1:0] ctl_wdata;
  logic [1:0] ctl_rdata;
  logic       consume;
  logic [7:0] state_hi;
  logic [7:0] state_lo;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] m_s;
  logic [1:0]  m_ctl;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  lfsr_rng_crc u_lfsr_rng_crc (
    .clk, .rst_n, .seed_wr, .seed_byte, .crc_valid, .crc_byte, .crc_ready,
    .ctl_wr, .ctl_wdata, .ctl_rdata, .consume, .state_hi, .state_lo
  );

  // Reference: thirteen shifts, rotate form with the tap bits folded in.
  function automatic logic [15:0] ref_rand(input logic [15:0] s);
    logic [15:0] r = s;
    for (int i = 0; i < 13; i++)
      r = {r[14:0], r[15]} ^ (r[15] ? 16'h8004 : 16'h0000);
    return r;
  endfunction

  // Reference: textbook byte-wise CRC16, MSB first, no reflection.
  function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] r = s ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a negedge: drive, update model, cross one edge, compare.
  task automatic tick(input logic sw, input logic [7:0] sb, input logic cv,
                      input logic [7:0] cb, input logic cw, input logic [1:0] cd,
                      input logic cons, input string tag);
    logic take;
    seed_wr = sw; seed_byte = sb; crc_valid = cv; crc_byte = cb;
    ctl_wr = cw; ctl_wdata = cd; consume = cons;
    #1;
    check("R7 ready", {15'd0, crc_ready}, {15'd0, !sw});
    take = cv && !sw;
    if (sw)                                       m_s = {m_s[7:0], sb};
    else if (take)                                m_s = ref_crc(m_s, cb);
    else if (m_ctl == 2'b01 || (cons && m_ctl != 2'b11)) begin
      m_s = ref_rand(m_s);
      if (m_ctl == 2'b01 && !cw) m_ctl = 2'b00;
    end
    if (cw) m_ctl = cd;
    @(posedge clk);
    @(negedge clk);
    check(tag, {state_hi, state_lo}, m_s);
    check({tag, " ctl"}, {14'd0, ctl_rdata}, {14'd0, m_ctl});
  endtask

  task automatic idle(input string tag);
    tick(0, 8'h00, 0, 8'h00, 0, 2'b00, 0, tag);
  endtask

  task automatic seed16(input logic [15:0] v);
    tick(1, v[15:8], 0, 8'h00, 0, 2'b00, 0, "R5");
    tick(1, v[7:0],  0, 8'h00, 0, 2'b00, 0, "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    seed_wr = 0; seed_byte = 0; crc_valid = 0; crc_byte = 0;
    ctl_wr = 0; ctl_wdata = 0; consume = 0;
    repeat (3) @(negedge clk);
    check("R1 state", {state_hi, state_lo}, 16'h0000);
    check("R1 ctl", {14'd0, ctl_rdata}, 16'h0000);
    rst_n = 1'b1;
    m_s = 16'h0000; m_ctl = 2'b00;

    // R8 zero lock-up
    tick(0, 0, 0, 0, 0, 2'b00, 1, "R8 zero");
    check("R8 zero literal", {state_hi, state_lo}, 16'h0000);

    // R5 seeding, then R2 random sequence
    seed16(16'hACE1);
    check("R5 literal", {state_hi, state_lo}, 16'hACE1);
    for (int i = 0; i < 20; i++) tick(0, 0, 0, 0, 0, 2'b00, 1, "R2");
    idle("R2 idle"); idle("R9 idle");
    tick(0, 0, 0, 0, 1, 2'b10, 0, "R3 write10");
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 0, 0, 2'b00, 1, "R2 alt");

    // R3 one-shot and self-clear
    tick(0, 0, 0, 0, 1, 2'b01, 0, "R3 arm");
    idle("R3 fire");
    idle("R3 after");
    // one-shot blocked by seed, then by CRC (R7)
    tick(0, 0, 0, 0, 1, 2'b01, 0, "R3 arm2");
    tick(1, 8'h5A, 0, 0, 0, 2'b00, 0, "R7 seed blocks once");
    tick(0, 0, 1, 8'hC3, 0, 2'b00, 0, "R7 crc blocks once");
    idle("R3 late fire");

    // R4 off ignores consume
    tick(0, 0, 0, 0, 1, 2'b11, 0, "R4 set");
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0, 2'b00, 1, "R4");
    tick(0, 0, 0, 0, 1, 2'b00, 0, "R4 back");

    // R8 0x8003 lock-up
    seed16(16'h8003);
    tick(0, 0, 0, 0, 0, 2'b00, 1, "R8 8003");
    check("R8 8003 literal", {state_hi, state_lo}, 16'h8003);
    tick(0, 0, 0, 0, 1, 2'b01, 0, "R8 arm");
    idle("R8 once");
    check("R8 once literal", {state_hi, state_lo}, 16'h8003);

    // R6 back-to-back CRC over "123456789"
    seed16(16'h0000);
    for (int i = 0; i < 9; i++) tick(0, 0, 1, 8'h31 + 8'(i), 0, 2'b00, 0, "R6");
    check("R6 check value", {state_hi, state_lo}, 16'hFEE8);

    // R7 all sources together
    tick(1, 8'h77, 1, 8'h99, 0, 2'b00, 1, "R7 seed wins");
    tick(0, 0, 1, 8'h42, 0, 2'b00, 1, "R7 crc wins");

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      tick(lcg[31:29] == 3'd0, lcg[7:0], lcg[28], lcg[15:8],
           lcg[27:25] == 3'd0, lcg[24:23], lcg[22], "R2 R6 mix");
    end
    idle("R9 end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule